// File: doc/BRIEF.md
# Calibration Sequencer with Multichip Sync Hold

This block orders a clock calibration into a first step, an optional hold for multichip alignment, and a final step. Software sets a start bit. The sequencer then runs the first step. If a sync-enable configuration bit is set, the sequencer holds until it has counted sixteen one-cycle pulses from the sync input receiver. It then runs the remaining step and reports completion. If sync is disabled, the hold is skipped. With sync enabled and no sync pulses arriving, the sequencer stays in the hold and never completes.

The analog calibration work is modelled by two cycle timers of parameterised length. The defaults are 64 cycles for the first step and 128 cycles for the remaining step. The sync pulse count is also a parameter, with a default of 16. The FSM states are IDLE, STEP1, SYNC_HOLD, STEP2 and DONE. The named transitions are:
- start: IDLE to STEP1
- step1_end_sync: STEP1 to SYNC_HOLD
- step1_end_nosync: STEP1 to STEP2
- sync_met: SYNC_HOLD to STEP2
- step2_end: STEP2 to DONE
- release: DONE to IDLE

Top module: `cal_sequencer`

## Requirements
- R1: A synchronous reset puts the sequencer in IDLE on the next clock edge, with busy low, done low and phase 0. It also clears the step timer and the sync pulse counter, so a hold entered after reset needs a full sixteen new pulses.
- R2: In IDLE, a start bit sampled high at a clock edge moves the sequencer to STEP1. Busy is high from that edge on.
- R3: STEP1 lasts exactly 64 clock cycles.
- R4: With sync enable high, the end of STEP1 enters SYNC_HOLD. Sync pulses that arrive before SYNC_HOLD are not counted.
- R5: SYNC_HOLD ends at the clock edge that samples the 16th sync pulse received in the hold. With a pulse every P cycles, the hold therefore lasts 16×P cycles.
- R6: With sync enable high and no sync pulse arriving, the sequencer stays in SYNC_HOLD with busy high and never asserts done.
- R7: With sync enable low, the end of STEP1 goes straight to STEP2 and no hold cycle occurs.
- R8: STEP2 lasts exactly 128 cycles and is followed by DONE. Total busy time is 192 cycles without sync and 192+16×P cycles with sync.
- R9: In DONE, done is high and busy is low for as long as start stays high. The first edge that samples start low returns the sequencer to IDLE.
- R10: The phase output encodes the state as 0 for IDLE, 1 for STEP1, 2 for SYNC_HOLD, 3 for STEP2 and 4 for DONE. Busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_start_i | input | 1 | Calibration start bit (level) |
| sync_en_i | input | 1 | Multichip sync enable configuration bit |
| sync_pulse_i | input | 1 | One-cycle pulse per sync period from the input receiver |
| cal_busy_o | output | 1 | Calibration in progress |
| cal_done_o | output | 1 | Calibration complete; held until start is cleared |
| cal_phase_o | output | 3 | Current phase code (0..4) |

## Verification
The assertions take two things for granted. First, the sync pulse is high for one cycle per period and is never high on consecutive cycles. Second, the sync enable bit is held steady while a calibration runs. The stimulus keeps within both. It changes the enable bit only in IDLE. It drives each sync pulse for exactly one cycle, with a gap of at least one low cycle before the next. Stray pulses sent during STEP1 follow the same one-cycle shape, so the test of R4 checks that they are ignored and does not probe how back-to-back pulses are handled.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_STEP1 = 3'd1,
        ST_HOLD  = 3'd2,
        ST_STEP2 = 3'd3,
        ST_DONE  = 3'd4
    } cal_state_e;

endpackage

// File: rtl/cal_step_timer.sv
module cal_step_timer #(
    parameter int MAX_LEN = 128
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run_i,
    input  logic [$clog2(MAX_LEN)-1:0] last_i,
    output logic                       end_o
);
    localparam int CW = $clog2(MAX_LEN);

    logic [CW-1:0] cnt_q;

    assign end_o = run_i && (cnt_q == last_i);

    always_ff @(posedge clk) begin
        if (rst || !run_i || end_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cal_sync_counter.sv
module cal_sync_counter #(
    parameter int NUM_PULSES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic pulse_i,
    output logic met_o
);
    localparam int CW = (NUM_PULSES < 2) ? 1 : $clog2(NUM_PULSES);
    localparam logic [CW-1:0] LAST = CW'(NUM_PULSES - 1);

    logic [CW-1:0] cnt_q;

    assign met_o = run_i && pulse_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i || met_o) begin
            cnt_q <= '0;
        end else if (pulse_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
    parameter int STEP1_CYCLES = 64,
    parameter int STEP2_CYCLES = 128,
    parameter int SYNC_PERIODS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cal_start_i,
    input  logic       sync_en_i,
    input  logic       sync_pulse_i,
    output logic       cal_busy_o,
    output logic       cal_done_o,
    output logic [2:0] cal_phase_o
);
    import cal_seq_pkg::*;

    localparam int MAX_LEN = (STEP1_CYCLES > STEP2_CYCLES) ? STEP1_CYCLES : STEP2_CYCLES;
    localparam int TW      = $clog2(MAX_LEN);
    localparam logic [TW-1:0] STEP1_LAST = TW'(STEP1_CYCLES - 1);
    localparam logic [TW-1:0] STEP2_LAST = TW'(STEP2_CYCLES - 1);

    cal_state_e    state_q, state_d;
    logic          timer_run, timer_end, sync_met;
    logic [TW-1:0] timer_last;

    assign timer_run  = (state_q == ST_STEP1) || (state_q == ST_STEP2);
    assign timer_last = (state_q == ST_STEP1) ? STEP1_LAST : STEP2_LAST;

    cal_step_timer #(.MAX_LEN(MAX_LEN)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (timer_run),
        .last_i (timer_last),
        .end_o  (timer_end)
    );

    cal_sync_counter #(.NUM_PULSES(SYNC_PERIODS)) sync_cnt_i (
        .clk     (clk),
        .rst     (rst),
        .run_i   (state_q == ST_HOLD),
        .pulse_i (sync_pulse_i),
        .met_o   (sync_met)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cal_start_i) state_d = ST_STEP1;                 // start
            ST_STEP1: if (timer_end)   state_d = sync_en_i ? ST_HOLD       // step1_end_sync
                                                           : ST_STEP2;     // step1_end_nosync
            ST_HOLD:  if (sync_met)    state_d = ST_STEP2;                 // sync_met
            ST_STEP2: if (timer_end)   state_d = ST_DONE;                  // step2_end
            ST_DONE:  if (!cal_start_i) state_d = ST_IDLE;                 // release
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output decode
    always_comb begin
        cal_busy_o  = 1'b0;
        cal_done_o  = 1'b0;
        cal_phase_o = 3'(state_q);
        unique case (state_q)
            ST_IDLE:                     ;
            ST_STEP1, ST_HOLD, ST_STEP2: cal_busy_o = 1'b1;
            ST_DONE:                     cal_done_o = 1'b1;
            default:                     ;
        endcase
    end
endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk (
    input logic       clk,
    input logic       rst,
    input logic       cal_start_i,
    input logic       sync_en_i,
    input logic       sync_pulse_i,
    input logic       cal_busy_o,
    input logic       cal_done_o,
    input logic [2:0] cal_phase_o
);
    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (cal_phase_o == 3'd0 && !cal_busy_o && !cal_done_o));

    a_r2_start_enters_step1: assert property (@(posedge clk) disable iff (rst)
        (cal_phase_o == 3'd0 && cal_start_i) |=> (cal_phase_o == 3'd1 && cal_busy_o));

    a_r4_hold_after_step1: assert property (@(posedge clk) disable iff (rst)
        (cal_phase_o == 3'd1 && sync_en_i) |=> (cal_phase_o == 3'd1 || cal_phase_o == 3'd2));

    a_r6_hold_waits_pulse: assert property (@(posedge clk) disable iff (rst)
        (cal_phase_o == 3'd2 && !sync_pulse_i) |=> (cal_phase_o == 3'd2 && !cal_done_o));

    a_r7_skip_hold: assert property (@(posedge clk) disable iff (rst)
        (cal_phase_o == 3'd1 && !sync_en_i) |=> (cal_phase_o != 3'd2));

    a_r8_done_from_step2: assert property (@(posedge clk) disable iff (rst)
        (cal_phase_o != 3'd4 && cal_phase_o != 3'd3) |=> !cal_done_o);

    a_r9_done_held: assert property (@(posedge clk) disable iff (rst)
        (cal_done_o && cal_start_i) |=> cal_done_o);

    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (cal_done_o && !cal_start_i) |=> (cal_phase_o == 3'd0));

    // R10
    always_comb begin
        a_r10_busy_done_excl: assert (!(cal_busy_o && cal_done_o));
        a_r10_phase_range:    assert (cal_phase_o <= 3'd4);
    end
endmodule

bind cal_sequencer cal_sequencer_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .cal_start_i  (cal_start_i),
    .sync_en_i    (sync_en_i),
    .sync_pulse_i (sync_pulse_i),
    .cal_busy_o   (cal_busy_o),
    .cal_done_o   (cal_done_o),
    .cal_phase_o  (cal_phase_o)
);

// File: tb/cal_sequencer_tb.sv
module cal_sequencer_tb_top;

    localparam int S1 = 64;
    localparam int S2 = 128;
    localparam int NP = 16;

    // vector: {sync_en, stray pulses in STEP1, period}
    localparam int NV = 5;
    localparam logic [9:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'd0},
        {1'b1, 1'b0, 8'd3},
        {1'b1, 1'b1, 8'd5},
        {1'b0, 1'b1, 8'd0},
        {1'b1, 1'b0, 8'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       sync_en = 1'b0;
    logic       pulse = 1'b0;
    logic       busy, done;
    logic [2:0] phase;

    int errors = 0;
    int checks = 0;
    int busy_cnt = 0;
    int ph_cnt [5];

    always #2 clk = ~clk;

    cal_sequencer dut_i (
        .clk          (clk),
        .rst          (rst),
        .cal_start_i  (start),
        .sync_en_i    (sync_en),
        .sync_pulse_i (pulse),
        .cal_busy_o   (busy),
        .cal_done_o   (done),
        .cal_phase_o  (phase)
    );

    always @(negedge clk) begin
        if (busy) busy_cnt++;
        if (phase <= 3'd4) ph_cnt[phase]++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        busy_cnt = 0;
        for (int i = 0; i < 5; i++) ph_cnt[i] = 0;
    endtask

    task automatic give_pulses(input int n, input int p);
        for (int i = 0; i < n; i++) begin
            repeat (p - 1) @(negedge clk);
            pulse = 1'b1;
            @(negedge clk);
            pulse = 1'b0;
        end
    endtask

    task automatic run_case(input bit en, input bit stray, input int p);
        int guard;
        @(negedge clk);
        sync_en = en;
        clear_counts();
        start = 1'b1;
        @(negedge clk);
        chk(phase == 3'd1 && busy, "R2", int'(phase), 1);
        if (stray) begin
            for (int i = 0; i < 3; i++) begin
                repeat (4) @(negedge clk);
                pulse = 1'b1;
                @(negedge clk);
                pulse = 1'b0;
            end
        end
        guard = 0;
        while (phase == 3'd1 && guard < 1000) begin @(negedge clk); guard++; end
        if (en) begin
            chk(phase == 3'd2, "R4", int'(phase), 2);
            give_pulses(NP, p);
        end else begin
            chk(phase == 3'd3, "R7", int'(phase), 3);
        end
        guard = 0;
        while (!done && guard < 2000) begin @(negedge clk); guard++; end
        chk(ph_cnt[1] == S1, "R3", ph_cnt[1], S1);
        chk(ph_cnt[2] == (en ? NP * p : 0), en ? "R5" : "R7", ph_cnt[2], en ? NP * p : 0);
        chk(ph_cnt[3] == S2, "R8", ph_cnt[3], S2);
        chk(busy_cnt == S1 + S2 + (en ? NP * p : 0), "R8", busy_cnt, S1 + S2 + (en ? NP * p : 0));
        chk(phase == 3'd4 && done && !busy, "R10", int'(phase), 4);
        repeat (5) @(negedge clk);
        chk(done && !busy, "R9", int'(done), 1);
        start = 1'b0;
        @(negedge clk);
        chk(phase == 3'd0 && !done && !busy, "R9", int'(phase), 0);
    endtask

    task automatic finish_report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(phase == 3'd0 && !busy && !done, "R1", int'(phase), 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            run_case(VEC[v][9], VEC[v][8], int'(VEC[v][7:0]));
        end

        // R6: no sync signal, never completes
        @(negedge clk);
        sync_en = 1'b1;
        start = 1'b1;
        repeat (3000) @(negedge clk);
        chk(phase == 3'd2 && busy && !done, "R6", int'(phase), 2);

        // R1: partial pulse count then reset clears everything
        give_pulses(7, 2);
        rst = 1'b1;
        start = 1'b0;
        @(negedge clk);
        chk(phase == 3'd0 && !busy && !done, "R1", int'(phase), 0);
        rst = 1'b0;
        run_case(1'b1, 1'b0, 2);
        chk(ph_cnt[2] == NP * 2, "R1", ph_cnt[2], NP * 2);

        // R1: reset during STEP1
        @(negedge clk);
        sync_en = 1'b0;
        start = 1'b1;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(phase == 3'd0 && !busy, "R1", int'(phase), 0);
        start = 1'b0;
        rst = 1'b0;
        run_case(1'b0, 1'b0, 0);

        finish_report();
    end
endmodule